// File: doc/BRIEF.md
# Event Density Histogram Auditor

This block observes single-cycle contention pulses from two monitored units and, for each unit, builds a histogram showing how densely events arrive. Time is divided into back-to-back observation windows of a programmed number of clock cycles. A per-channel accumulator counts pulses inside the current window. When the window closes, that count is used as an address into the channel's own 128-entry histogram, the addressed entry is incremented, and the accumulator starts over. The result records how often a window held zero events, one event, two events and so on. It does not keep a plain running total.

Software fetches the histograms through a registered read port that has a channel select and a bin address. At the end of a time slice it clears both histograms with one strobe. The sweep that follows takes one cycle per bin, and a busy flag stays high for the whole sweep.

A small controller has three states. ST_START lasts exactly one cycle after reset and loads the window timer. It then moves unconditionally to ST_RUN. In ST_RUN, windows run and histograms update. A clear strobe moves the controller from ST_RUN to ST_CLEAR. ST_CLEAR zeroes one bin of both channels per cycle and returns to ST_RUN after the last bin has been cleared.

Top module: `evt_density_auditor`

## Requirements
- R1: After reset, every histogram bin of both channels reads zero, `rd_data` is zero and `clr_busy` is low.
- R2: The window length is L = `win_len` cycles. Consecutive windows follow with no gap. The first window begins on the first clock edge after reset is released, so window k covers edges kL through (k+1)L-1 and closes on edge (k+1)L. `win_len` is sampled each time the timer reloads.
- R3: For each enabled channel, the count of pulses in a window selects a bin of that channel's histogram, and that bin is incremented when the window closes.
- R4: A pulse on the same edge that closes a window belongs to the new window, whose accumulator starts at 1.
- R5: A window count above 127 is recorded in bin 127.
- R6: An accumulator saturates at 65535 and never wraps. A window with 65540 pulses is therefore recorded in bin 127.
- R7: A histogram bin saturates at 65535 and never wraps.
- R8: When a channel's enable bit (`chan_en[0]` for channel 0, `chan_en[1]` for channel 1) is low, its accumulator is held at zero and its histogram is never updated.
- R9: `rd_data` returns histogram entry `rd_addr` of channel `rd_chan` (0 or 1), registered one cycle after the address is presented.
- R10: A `clr_req` pulse while not busy raises `clr_busy` for exactly 128 cycles and zeroes every bin of both channels. Windows that close during the sweep do not update any histogram. A `clr_req` during the sweep is ignored.
- R11: A `win_len` of zero behaves as a window of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_len | input | 32 | Window length in cycles (0 acts as 1) |
| chan_en | input | 2 | Per-channel audit enable |
| evt_pulse | input | 2 | Per-channel contention event pulse |
| rd_chan | input | 1 | Channel select for reads |
| rd_addr | input | 7 | Histogram bin address for reads |
| rd_data | output | 16 | Registered histogram entry |
| clr_req | input | 1 | Strobe that starts a histogram clear |
| clr_busy | output | 1 | High while the clear sweep runs |

## Verification
Some properties are checked by assertions on every cycle: the accumulator steps by one per pulse, it restarts at one when a pulse lands on a window-closing edge, it holds at zero while its channel is disabled, and it stops at its ceiling. The assertions also confirm that a clear strobe raises the busy flag and that the sweep lasts exactly 128 cycles even when the strobe is repeated. Other behaviour can only be shown by the bench's scenarios, because it requires reading whole histograms back: the window lengths, the density-to-bin mapping, clamping into the top bin, histogram saturation after tens of thousands of windows, zero-length windows, and the absence of updates during a clear.

// File: rtl/eda_pkg.sv
package eda_pkg;
    typedef enum logic [1:0] {
        ST_START = 2'd0,
        ST_RUN   = 2'd1,
        ST_CLEAR = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/eda_win_timer.sv
module eda_win_timer #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             win_end
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload_val;

    // zero length behaves as a single-cycle window
    assign reload_val = (len == '0) ? '0 : len - CNT_W'(1);
    assign win_end    = !load && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load || cnt_q == '0) begin
            cnt_q <= reload_val;
        end else begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end
endmodule

// File: rtl/eda_chan_accum.sv
module eda_chan_accum #(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             pulse,
    input  logic             win_end,
    output logic [ACC_W-1:0] acc
);
    localparam logic [ACC_W-1:0] ACC_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (!en) begin
            acc <= '0;
        end else if (win_end) begin
            acc <= pulse ? ACC_W'(1) : '0;
        end else if (pulse && acc != ACC_MAX) begin
            acc <= acc + ACC_W'(1);
        end
    end
endmodule

// File: rtl/eda_hist_bank.sv
module eda_hist_bank #(
    parameter int BINS  = 128,
    parameter int BIN_W = 16,
    parameter int ACC_W = 16,
    localparam int AW   = $clog2(BINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic [ACC_W-1:0] acc,
    input  logic             clr_en,
    input  logic [AW-1:0]    clr_idx,
    input  logic [AW-1:0]    rd_addr,
    output logic [BIN_W-1:0] rd_val
);
    localparam logic [BIN_W-1:0] BIN_MAX = '1;
    localparam logic [ACC_W-1:0] TOP_BIN = ACC_W'(BINS - 1);

    logic [BIN_W-1:0] mem_q [BINS];
    logic [AW-1:0]    bin_sel;

    // counts beyond the last bin land in the last bin
    assign bin_sel = (acc > TOP_BIN) ? AW'(BINS - 1) : acc[AW-1:0];
    assign rd_val  = mem_q[rd_addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < BINS; i++) begin
                mem_q[i] <= '0;
            end
        end else if (clr_en) begin
            mem_q[clr_idx] <= '0;
        end else if (upd && mem_q[bin_sel] != BIN_MAX) begin
            mem_q[bin_sel] <= mem_q[bin_sel] + BIN_W'(1);
        end
    end
endmodule

// File: rtl/evt_density_auditor.sv
module evt_density_auditor #(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 32,
    parameter int ACC_W  = 16,
    parameter int BINS   = 128,
    parameter int BIN_W  = 16,
    localparam int AW    = $clog2(BINS),
    localparam int CSW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  win_len,
    input  logic [NUM_CH-1:0] chan_en,
    input  logic [NUM_CH-1:0] evt_pulse,
    input  logic [CSW-1:0]    rd_chan,
    input  logic [AW-1:0]     rd_addr,
    output logic [BIN_W-1:0]  rd_data,
    input  logic              clr_req,
    output logic              clr_busy
);
    import eda_pkg::*;

    ctl_state_e state_q, state_d;
    logic [AW-1:0] clr_idx_q;
    logic timer_load, sweeping, win_end;
    logic [NUM_CH-1:0][ACC_W-1:0] acc_all;
    logic [BIN_W-1:0] bank_val [NUM_CH];

    // next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_START: state_d = ST_RUN;
            ST_RUN:   if (clr_req) state_d = ST_CLEAR;
            ST_CLEAR: if (clr_idx_q == AW'(BINS - 1)) state_d = ST_RUN;
            default:  state_d = ST_START;
        endcase
    end

    // state register and sweep index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_START;
            clr_idx_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_CLEAR) clr_idx_q <= clr_idx_q + AW'(1);
            else                     clr_idx_q <= '0;
        end
    end

    // output process
    always_comb begin
        timer_load = 1'b0;
        sweeping   = 1'b0;
        unique case (state_q)
            ST_START: timer_load = 1'b1;
            ST_RUN:   ;
            ST_CLEAR: sweeping = 1'b1;
            default:  timer_load = 1'b1;
        endcase
    end
    assign clr_busy = sweeping;

    eda_win_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(timer_load), .len(win_len), .win_end(win_end)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        eda_chan_accum #(.ACC_W(ACC_W)) u_acc (
            .clk(clk), .rst_n(rst_n), .en(chan_en[c]), .pulse(evt_pulse[c]),
            .win_end(win_end), .acc(acc_all[c])
        );
        eda_hist_bank #(.BINS(BINS), .BIN_W(BIN_W), .ACC_W(ACC_W)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .upd(win_end && chan_en[c] && !sweeping),
            .acc(acc_all[c]), .clr_en(sweeping), .clr_idx(clr_idx_q),
            .rd_addr(rd_addr), .rd_val(bank_val[c])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= bank_val[rd_chan];
    end
endmodule

// File: rtl/eda_checker.sv
module eda_checker #(
    parameter int NUM_CH = 2,
    parameter int ACC_W  = 16,
    parameter int BINS   = 128
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_CH-1:0]            chan_en,
    input logic [NUM_CH-1:0]            evt_pulse,
    input logic                         win_end,
    input logic [NUM_CH-1:0][ACC_W-1:0] acc_all,
    input logic                         clr_req,
    input logic                         clr_busy
);
    localparam logic [ACC_W-1:0] ACC_MAX = '1;

    logic seen_q;
    int   busy_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q     <= 1'b0;
            busy_run_q <= 0;
        end else begin
            seen_q     <= 1'b1;
            busy_run_q <= clr_busy ? busy_run_q + 1 : 0;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            (chan_en[c] && !win_end && evt_pulse[c] && acc_all[c] != ACC_MAX)
            |=> acc_all[c] == $past(acc_all[c]) + ACC_W'(1)); // R3
        AST_NEW_WIN_ONE: assert property (@(posedge clk) disable iff (!rst_n)
            (chan_en[c] && win_end && evt_pulse[c]) |=> acc_all[c] == ACC_W'(1)); // R4
        AST_ACC_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
            (chan_en[c] && !win_end && acc_all[c] == ACC_MAX) |=> acc_all[c] == ACC_MAX); // R6
        AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            !chan_en[c] |=> acc_all[c] == '0); // R8
    end

    AST_CLEAR_START: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && clr_req && !clr_busy) |=> clr_busy); // R10
    AST_CLEAR_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_busy && busy_run_q != 0) |-> busy_run_q == BINS); // R10
    AST_CLEAR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run_q <= BINS); // R10
endmodule

bind evt_density_auditor eda_checker #(.NUM_CH(NUM_CH), .ACC_W(ACC_W), .BINS(BINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .evt_pulse(evt_pulse),
    .win_end(win_end), .acc_all(acc_all), .clr_req(clr_req), .clr_busy(clr_busy)
);

// File: tb/evt_density_auditor_bench.sv
module evt_density_auditor_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 195000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] win_len = 32'd4;
    logic [1:0]  chan_en = 2'b00;
    logic [1:0]  evt_pulse = 2'b00;
    logic        rd_chan = 1'b0;
    logic [6:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        clr_req = 1'b0;
    logic        clr_busy;

    int errors = 0;
    int checks = 0;
    int exp_h [2][128];

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_density_auditor u_evt_density_auditor (
        .clk(clk), .rst_n(rst_n), .win_len(win_len), .chan_en(chan_en),
        .evt_pulse(evt_pulse), .rd_chan(rd_chan), .rd_addr(rd_addr),
        .rd_data(rd_data), .clr_req(clr_req), .clr_busy(clr_busy)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit pat(int mode, int ch, int e, int len);
        int k, off;
        k = e / len;
        off = e % len;
        case (mode)
            0: return (ch == 0) ? (off < k % (len + 1)) : (off < (3 * k) % (len + 1));
            1: return (ch == 0) && (e <= len);
            2: return (ch == 0) ? 1'b1 : (e % 3 == 0);
            3: return (e % 2 == 0);
            4: return (ch == 0) && (e % 2 == 1);
            6: return (ch == 0);
            default: return 1'b0;
        endcase
    endfunction

    task automatic read_all(string tag);
        for (int ch = 0; ch < 2; ch++) begin
            for (int a = 0; a < 128; a++) begin
                rd_chan = ch[0];
                rd_addr = a[6:0];
                @(negedge clk);
                check($sformatf("%s ch%0d bin%0d", tag, ch, a), int'(rd_data), exp_h[ch][a]);
            end
        end
    endtask

    task automatic run_scn(int cfg, int nwin, int mode, logic [1:0] en, string tag);
        int len, cnt, b;
        len = (cfg == 0) ? 1 : cfg;
        rst_n = 1'b0; win_len = cfg; chan_en = en; evt_pulse = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int e = 0; e <= nwin * len; e++) begin
            evt_pulse[0] = (e < nwin * len) && pat(mode, 0, e, len);
            evt_pulse[1] = (e < nwin * len) && pat(mode, 1, e, len);
            @(negedge clk);
        end
        chan_en = '0; evt_pulse = '0;
        for (int ch = 0; ch < 2; ch++) begin
            for (int a = 0; a < 128; a++) exp_h[ch][a] = 0;
            if (en[ch]) begin
                for (int k = 0; k < nwin; k++) begin
                    cnt = 0;
                    for (int e = k * len; e < (k + 1) * len; e++) cnt += pat(mode, ch, e, len);
                    if (cnt > 65535) cnt = 65535;
                    b = (cnt > 127) ? 127 : cnt;
                    if (exp_h[ch][b] < 65535) exp_h[ch][b]++;
                end
            end
        end
        read_all(tag);
    endtask

    initial begin
        int busy_cycles;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 rd_data", int'(rd_data), 0);
        check("R1 clr_busy", int'(clr_busy), 0);
        rst_n = 1'b1;
        for (int ch = 0; ch < 2; ch++) for (int a = 0; a < 128; a++) exp_h[ch][a] = 0;
        read_all("R1 R9");

        run_scn(4, 24, 0, 2'b11, "R2 R3 R9 len4");
        run_scn(7, 20, 0, 2'b11, "R2 R3 len7");
        run_scn(5, 3, 1, 2'b01, "R4 end-edge pulse");
        run_scn(300, 2, 2, 2'b11, "R5 clamp");
        run_scn(6, 10, 3, 2'b01, "R8 disabled");
        run_scn(0, 10, 4, 2'b01, "R11 zero len");

        // R10: clear with repeat strobe, windows closing during sweep
        run_scn(4, 24, 0, 2'b11, "R10 prefill");
        win_len = 32'd1;
        clr_req = 1'b1;
        @(negedge clk);
        clr_req = 1'b0;
        chan_en = 2'b11;
        busy_cycles = 0;
        while (clr_busy && busy_cycles < 400) begin
            busy_cycles++;
            clr_req = (busy_cycles == 50);
            @(negedge clk);
        end
        chan_en = 2'b00; clr_req = 1'b0;
        check("R10 busy length", busy_cycles, 128);
        for (int ch = 0; ch < 2; ch++) for (int a = 0; a < 128; a++) exp_h[ch][a] = 0;
        read_all("R10 cleared");

        run_scn(1, 65540, 5, 2'b01, "R7 bin saturate");
        run_scn(65540, 1, 6, 2'b01, "R6 acc saturate");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule